// File: doc/BRIEF.md
# Scroll and Toggle LED Controller

This block drives a row of four indicator LEDs and works in two modes. Out of reset it is in scroll mode: a single lit LED steps from one output to the next at a fixed step period. A direction input picks whether the lit LED moves toward higher or lower indices. A pulse on any of the four button inputs stops the scroll and moves the block into toggle mode. In toggle mode each button pulse inverts its own LED.

An inactivity timer runs while the block is in toggle mode. Every button pulse restarts it. When it reaches its limit the block returns to scroll mode and resumes from the position where the scroll had stopped. The four most significant bits of that timer are brought out so that a status display can show how far the timeout has run.

A remote override select hands the LEDs to a host. While it is set, the LEDs show the remote switch bits XORed with the remote pushbutton bits. A held pushbutton therefore inverts the switch-set pattern only for as long as it is held. The internal modes keep running under the override. Button sensing and the host link sit outside this block: the button inputs arrive as one-cycle pulses in the block's clock domain.

Top module: `led_mode_ctrl`

## Requirements
- R1: While reset is asserted and directly after it, the block is in scroll mode, `led` is 4'b0001 (only bit 0 lit) and `tmo_view` is 0.
- R2: In scroll mode with `scroll_dir` = 0, the lit LED moves from index i to index i+1 once every STEP_CYCLES clocks, and index 3 wraps to index 0. The first step comes STEP_CYCLES clocks after reset is released.
- R3: In scroll mode with `scroll_dir` = 1, the lit LED moves from index i to index i-1 once every STEP_CYCLES clocks, and index 0 wraps to index 3.
- R4: A clock edge that sees any bit of `btn_press` set while in scroll mode moves the block into toggle mode at that edge. The toggle pattern is cleared to 4'b0000, the press itself is not applied, and the scroll position is frozen.
- R5: In toggle mode, a clock edge with `btn_press` bit N set inverts LED N. Several bits set in the same cycle invert all of them at once.
- R6: After TIMEOUT_CYCLES consecutive clock edges in toggle mode with no press, the block is back in scroll mode. `led` shows the frozen scroll position, and the next step comes STEP_CYCLES clocks later. Before that count is reached, the block stays in toggle mode.
- R7: Every press in toggle mode restarts the inactivity count from zero. This includes a press in the very cycle in which the timeout would otherwise expire: the block stays in toggle mode and applies the press.
- R8: `tmo_view` equals the four most significant bits of the inactivity count, which is the number of clock edges since the last press in toggle mode. It is 0 in scroll mode.
- R9: When `host_ovr` = 1, `led` equals `host_sw` XOR `host_pb` in the same cycle, without waiting for a clock edge. When `host_ovr` = 0, `led` shows the internal scroll or toggle pattern.
- R10: A press that arrives in the same cycle as a scroll step takes priority over it. The scroll does not advance, and the position shown after the later timeout is the one from before that press.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| btn_press | input | NUM_LED | One-cycle press pulses, bit N for button N |
| scroll_dir | input | 1 | Scroll direction: 0 toward higher index, 1 toward lower |
| host_ovr | input | 1 | 1 hands the LEDs to the host pattern |
| host_sw | input | NUM_LED | Host switch levels |
| host_pb | input | NUM_LED | Host momentary pushbutton levels |
| led | output | NUM_LED | LED drive, 1 lights the LED |
| tmo_view | output | 4 | Upper four bits of the inactivity count |

States: SCROLL (reset state) and TOGGLE. Transitions: SCROLL to TOGGLE on any press. TOGGLE to SCROLL on timeout expiry with no press. TOGGLE stays in TOGGLE on a press or while the count is still running.

## Verification
Two pairs of events can fall on the same clock edge: a press and the timeout expiry, and a press and a scroll step tick. The bench counts edges from the last press and places a press in the exact cycle where the inactivity count sits at its final value. It then checks that the LEDs still show the toggle pattern with that press applied. It also places a press on the edge where the step tick fires while scrolling, waits out the timeout, and checks that the resumed position did not advance. A further step then confirms that the step timer restarted on the return to scroll mode.

// File: rtl/led_mode_pkg.sv
package led_mode_pkg;

    typedef enum logic {
        MODE_SCROLL = 1'b0,
        MODE_TOGGLE = 1'b1
    } lmc_mode_e;

    // Counter width able to hold values 0..limit-1, never narrower than floor_w
    function automatic int unsigned cnt_width(input int unsigned limit,
                                              input int unsigned floor_w);
        int unsigned w;
        w = (limit > 1) ? $clog2(limit) : 1;
        return (w < floor_w) ? floor_w : w;
    endfunction

endpackage

// File: rtl/lmc_step_timer.sv
module lmc_step_timer #(
    parameter int unsigned STEP_CYCLES = 333_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    import led_mode_pkg::*;

    localparam int unsigned STEP_W = cnt_width(STEP_CYCLES, 1);
    localparam logic [STEP_W-1:0] STEP_LAST = STEP_W'(STEP_CYCLES - 1);

    logic [STEP_W-1:0] step_cnt_q;

    assign tick = run && (step_cnt_q == STEP_LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            step_cnt_q <= '0;
        end else if (!run || tick) begin
            step_cnt_q <= '0;
        end else begin
            step_cnt_q <= step_cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/lmc_idle_timer.sv
module lmc_idle_timer #(
    parameter int unsigned TIMEOUT_CYCLES = 16_650_000,
    parameter int unsigned CNT_W          = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    output logic [CNT_W-1:0] count,
    output logic             expire
);
    localparam logic [CNT_W-1:0] IDLE_LAST = CNT_W'(TIMEOUT_CYCLES - 1);

    logic [CNT_W-1:0] idle_cnt_q;

    assign count  = idle_cnt_q;
    assign expire = run && !restart && (idle_cnt_q == IDLE_LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idle_cnt_q <= '0;
        end else if (!run || restart || expire) begin
            idle_cnt_q <= '0;
        end else begin
            idle_cnt_q <= idle_cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/lmc_scroll_ring.sv
module lmc_scroll_ring #(
    parameter int unsigned NUM_LED = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               advance,
    input  logic               dir_down,
    output logic [NUM_LED-1:0] pos
);
    logic [NUM_LED-1:0] pos_q;
    logic [NUM_LED-1:0] pos_up;
    logic [NUM_LED-1:0] pos_down;

    generate
        if (NUM_LED == 1) begin : g_single
            assign pos_up   = pos_q;
            assign pos_down = pos_q;
        end else begin : g_rotate
            assign pos_up   = {pos_q[NUM_LED-2:0], pos_q[NUM_LED-1]};
            assign pos_down = {pos_q[0], pos_q[NUM_LED-1:1]};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos_q <= NUM_LED'(1);
        end else if (advance) begin
            pos_q <= dir_down ? pos_down : pos_up;
        end
    end

    assign pos = pos_q;

endmodule

// File: rtl/led_mode_ctrl.sv
module led_mode_ctrl #(
    parameter int unsigned NUM_LED        = 4,
    parameter int unsigned TIMEOUT_CYCLES = 16_650_000,
    parameter int unsigned STEP_CYCLES    = 333_000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_LED-1:0] btn_press,
    input  logic               scroll_dir,
    input  logic               host_ovr,
    input  logic [NUM_LED-1:0] host_sw,
    input  logic [NUM_LED-1:0] host_pb,
    output logic [NUM_LED-1:0] led,
    output logic [3:0]         tmo_view
);
    import led_mode_pkg::*;

    localparam int unsigned CNT_W = cnt_width(TIMEOUT_CYCLES, 4);

    lmc_mode_e          mode_q;
    lmc_mode_e          mode_d;
    logic               any_press;
    logic               step_tick;
    logic               idle_expire;
    logic [CNT_W-1:0]   idle_count;
    logic [NUM_LED-1:0] scroll_pos;
    logic [NUM_LED-1:0] tog_q;
    logic               in_scroll;
    logic               in_toggle;

    assign any_press = |btn_press;
    assign in_scroll = (mode_q == MODE_SCROLL);
    assign in_toggle = (mode_q == MODE_TOGGLE);

    // Next-state logic
    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            MODE_SCROLL: begin
                if (any_press) begin
                    mode_d = MODE_TOGGLE;
                end
            end
            MODE_TOGGLE: begin
                if (idle_expire) begin
                    mode_d = MODE_SCROLL;
                end
            end
            default: mode_d = MODE_SCROLL;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= MODE_SCROLL;
        end else begin
            mode_q <= mode_d;
        end
    end

    lmc_step_timer #(
        .STEP_CYCLES(STEP_CYCLES)
    ) u_step (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (in_scroll),
        .tick (step_tick)
    );

    lmc_scroll_ring #(
        .NUM_LED(NUM_LED)
    ) u_ring (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (step_tick && !any_press),
        .dir_down(scroll_dir),
        .pos     (scroll_pos)
    );

    lmc_idle_timer #(
        .TIMEOUT_CYCLES(TIMEOUT_CYCLES),
        .CNT_W         (CNT_W)
    ) u_idle (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (in_toggle),
        .restart(any_press),
        .count  (idle_count),
        .expire (idle_expire)
    );

    // One toggle cell per LED
    generate
        for (genvar i = 0; i < NUM_LED; i++) begin : g_tog
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    tog_q[i] <= 1'b0;
                end else if (in_scroll && any_press) begin
                    tog_q[i] <= 1'b0;
                end else if (in_toggle && btn_press[i]) begin
                    tog_q[i] <= ~tog_q[i];
                end
            end
        end
    endgenerate

    // Output process
    always_comb begin
        if (host_ovr) begin
            led = host_sw ^ host_pb;
        end else begin
            unique case (mode_q)
                MODE_SCROLL: led = scroll_pos;
                MODE_TOGGLE: led = tog_q;
                default:     led = scroll_pos;
            endcase
        end
        tmo_view = idle_count[CNT_W-1 -: 4];
    end

endmodule

// File: rtl/lmc_checker.sv
module lmc_checker #(
    parameter int unsigned NUM_LED        = 4,
    parameter int unsigned TIMEOUT_CYCLES = 16,
    parameter int unsigned CNT_W          = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               in_toggle,
    input logic [NUM_LED-1:0] btn_press,
    input logic [NUM_LED-1:0] tog,
    input logic [NUM_LED-1:0] ring,
    input logic [CNT_W-1:0]   idle_cnt,
    input logic [3:0]         tmo_view
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT_CYCLES - 1);

    a_r2_ring_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(ring) == 1);

    a_r4_enter_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_toggle && |btn_press) |=> (in_toggle && tog == '0));

    a_r5_press_flips: assert property (@(posedge clk) disable iff (!rst_n)
        (in_toggle && |btn_press) |=> (tog == $past(tog ^ btn_press)));

    a_r6_no_early_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (in_toggle && idle_cnt < LAST) |=> in_toggle);

    a_r7_press_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        (in_toggle && |btn_press) |=> (in_toggle && idle_cnt == '0));

    a_r8_view_zero_scroll: assert property (@(posedge clk) disable iff (!rst_n)
        !in_toggle |-> tmo_view == 4'd0);

    a_r10_press_freezes_ring: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_toggle && |btn_press) |=> $stable(ring));

endmodule

bind led_mode_ctrl lmc_checker #(
    .NUM_LED       (NUM_LED),
    .TIMEOUT_CYCLES(TIMEOUT_CYCLES),
    .CNT_W         (CNT_W)
) u_lmc_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_toggle(in_toggle),
    .btn_press(btn_press),
    .tog      (tog_q),
    .ring     (scroll_pos),
    .idle_cnt (idle_count),
    .tmo_view (tmo_view)
);

// File: tb/tb_led_mode_ctrl.sv
`timescale 1ns/1ps
module tb_led_mode_ctrl;

    localparam int unsigned T_OUT = 40;
    localparam int unsigned T_STP = 4;
    localparam int unsigned NVEC  = 5;
    // {press, expected led} applied in toggle mode
    localparam logic [7:0] VEC [NVEC] = '{
        {4'b0001, 4'b0001},
        {4'b0110, 4'b0111},
        {4'b0001, 4'b0110},
        {4'b1111, 4'b1001},
        {4'b1000, 4'b0001}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] btn_press = '0;
    logic       scroll_dir = 1'b0;
    logic       host_ovr = 1'b0;
    logic [3:0] host_sw = '0;
    logic [3:0] host_pb = '0;
    logic [3:0] led;
    logic [3:0] tmo_view;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    led_mode_ctrl #(
        .NUM_LED(4),
        .TIMEOUT_CYCLES(T_OUT),
        .STEP_CYCLES(T_STP)
    ) dut (
        .clk(clk), .rst_n(rst_n), .btn_press(btn_press), .scroll_dir(scroll_dir),
        .host_ovr(host_ovr), .host_sw(host_sw), .host_pb(host_pb),
        .led(led), .tmo_view(tmo_view)
    );

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic press(input logic [3:0] p);
        btn_press = p;
        edges(1);
        btn_press = '0;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        edges(3);
        chk("R1 led in reset", led, 4'b0001);
        chk("R1 tmo_view in reset", tmo_view, 4'd0);
        rst_n = 1'b1;
        chk("R1 led after reset", led, 4'b0001);

        // R2 upward scroll
        edges(3);
        chk("R2 no step before period", led, 4'b0001);
        edges(1);
        chk("R2 step 0->1", led, 4'b0010);
        edges(4);
        chk("R2 step 1->2", led, 4'b0100);
        edges(4);
        chk("R2 step 2->3", led, 4'b1000);
        edges(4);
        chk("R2 wrap 3->0", led, 4'b0001);

        // R3 downward scroll
        scroll_dir = 1'b1;
        edges(4);
        chk("R3 wrap 0->3", led, 4'b1000);
        edges(4);
        chk("R3 step 3->2", led, 4'b0100);

        // R4 enter toggle
        press(4'b0010);
        chk("R4 toggle entry clears", led, 4'b0000);
        chk("R8 view zero at entry", tmo_view, 4'd0);

        // R5 vector table
        for (int i = 0; i < NVEC; i++) begin
            press(VEC[i][7:4]);
            chk("R5 toggle vector", led, VEC[i][3:0]);
        end

        // R8 / R6 counting
        edges(20);
        chk("R8 view after 20 idle", tmo_view, 4'd5);
        chk("R6 still toggle mid-count", led, 4'b0001);
        edges(19);
        chk("R6 still toggle at last count", led, 4'b0001);

        // R7 press in expiry cycle
        press(4'b0100);
        chk("R7 press at expiry kept toggle", led, 4'b0101);
        chk("R7 count restarted", tmo_view, 4'd0);
        edges(39);
        chk("R6 toggle one before timeout", led, 4'b0101);
        edges(1);
        chk("R6 resume frozen position", led, 4'b0100);
        chk("R8 view zero in scroll", tmo_view, 4'd0);

        // R10 press on step tick
        edges(3);
        press(4'b1000);
        chk("R4 re-entry clears toggles", led, 4'b0000);
        edges(40);
        chk("R10 no step on press tick", led, 4'b0100);
        edges(4);
        chk("R6 step timer restarted", led, 4'b0010);

        // R9 override
        host_ovr = 1'b1;
        host_sw = 4'b1010;
        #1;
        chk("R9 switches shown", led, 4'b1010);
        host_pb = 4'b0011;
        #1;
        chk("R9 pushbutton inverts", led, 4'b1001);
        host_pb = 4'b0000;
        #1;
        chk("R9 release restores", led, 4'b1010);
        host_ovr = 1'b0;
        #1;
        chk("R9 internal pattern back", led, 4'b0010);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule